// File: doc/BRIEF.md
# Predicated Move Gather/Scatter Sequencer

This block turns one register move into a stream of register-copy requests. Each side of the move, source and destination, is either a single scalar register or a vector of consecutive registers starting at a base index. Each vector side has its own predicate mask. The sequencer keeps one element position per side. On every step, a vector side first passes over the elements whose predicate bit is clear. The block then requests one copy from register (source base + source position) to register (destination base + destination position). After that copy, only the positions of the vector sides move on.

One loop covers every kind of move. A scalar source with a vector destination gives a splat, or a sparse splat when the destination mask has gaps. A vector source with a scalar destination gives an extract. Vector to vector gives a plain copy when both masks are full. It gives a gather when only the source mask has gaps, a scatter when only the destination mask has gaps, and a combined gather/scatter when both do.

The issue stage pulses `start` with the vector length, both masks, both resolved base registers and both vector flags. It then takes copy requests through a valid/ready pair until `done` pulses. The register file, the predicate lookup and element-width handling are outside this block.

Top module: `pred_move_seq`

## Requirements
- R1: Out of reset, and at any time while `busy` is low, `busy`, `cpValid` and `done` are all low.
- R2: A `start` pulse while idle captures all operands and raises `busy` in the next cycle. A `start` while busy is ignored, and so are operand changes while busy: the running move continues with the operands captured at its start.
- R3: Each request carries `cpSrc` = srcBase + source position and `cpDst` = dstBase + destination position, both modulo 2^REG_W. A scalar side always uses position 0. A vector side uses the lowest position at or above its current position whose mask bit (bit k for element k) is 1.
- R4: When a request is accepted (`cpValid` and `cpReady` both high at a clock edge), each vector side's position becomes the used position plus one. A scalar side's position does not change.
- R5: The move ends without issuing a request as soon as either side's effective position is at or above the vector length. A vector length of 0, an empty mask on a vector side, or mask bits set only at or above the vector length all give zero requests.
- R6: When both sides are scalar and the vector length is at least 1, exactly one request is issued.
- R7: `done` is high for exactly one cycle. It comes in the cycle after the last accepted request, or in the cycle after `start` when no request is issued. It is never high together with `cpValid`, and `busy` is low in the cycle after it.
- R8: While `cpValid` is high and `cpReady` is low, the request stays valid and `cpSrc` and `cpDst` hold their values into the next cycle.
- R9: The predicate mask of a scalar side has no effect on the requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move; sampled only while idle |
| vecLen | input | IDX_W | Vector length, 0 to VLMAX |
| srcMask | input | VLMAX | Source predicate, bit k enables element k |
| dstMask | input | VLMAX | Destination predicate, bit k enables element k |
| srcBase | input | REG_W | Resolved source base register |
| dstBase | input | REG_W | Resolved destination base register |
| srcVec | input | 1 | Source side is a vector |
| dstVec | input | 1 | Destination side is a vector |
| cpReady | input | 1 | Consumer accepts the current copy request |
| busy | output | 1 | A move is in progress |
| cpValid | output | 1 | A copy request is presented |
| cpSrc | output | REG_W | Source register of the request |
| cpDst | output | REG_W | Destination register of the request |
| done | output | 1 | One-cycle end-of-move pulse |

## Verification
Source-side skipping and destination-side skipping happen in the same cycle as the copy they lead to. A gather/scatter move can therefore jump both positions over gaps at different places, and the request and the end decision must still come out of that single cycle. The bench provokes this with source and destination masks whose clear bits sit at different positions, under both steady and stalled `cpReady`. It compares every accepted request, in order, with a reference walk computed from the requirements. It also checks that `done` lands exactly one cycle after the last accepted request, including moves where the skip alone runs past the vector length.

// File: rtl/pms_pkg.sv
package pms_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear positions
    logic step;   // current request accepted, advance positions
  } seqStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/pms_first_set.sv
// Lowest set mask bit at or above a starting position; returns VLMAX when none.
module pms_first_set #(
  parameter int VLMAX = 8,
  localparam int IDX_W = $clog2(VLMAX + 1)
) (
  input  logic [VLMAX-1:0] mask,
  input  logic [IDX_W-1:0] fromPos,
  output logic [IDX_W-1:0] hitPos
);

  always_comb begin
    hitPos = IDX_W'(VLMAX);
    for (int k = VLMAX - 1; k >= 0; k--) begin
      if (mask[k] && (IDX_W'(k) >= fromPos)) begin
        hitPos = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/pms_datapath.sv
module pms_datapath
  import pms_pkg::*;
#(
  parameter int VLMAX = 8,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [IDX_W-1:0] vecLen,
  input  logic [VLMAX-1:0] srcMask,
  input  logic [VLMAX-1:0] dstMask,
  input  logic [REG_W-1:0] srcBase,
  input  logic [REG_W-1:0] dstBase,
  input  logic             srcVec,
  input  logic             dstVec,
  output logic             endHit,
  output logic [REG_W-1:0] cpSrc,
  output logic [REG_W-1:0] cpDst
);

  // Captured operands
  logic [IDX_W-1:0] vlR;
  logic [VLMAX-1:0] sMaskR, dMaskR;
  logic [REG_W-1:0] sBaseR, dBaseR;
  logic             sVecR, dVecR;

  // Element positions and the one-shot flag for scalar-to-scalar moves
  logic [IDX_W-1:0] iCur, jCur;
  logic             spent;

  logic [IDX_W-1:0] iHit, jHit;
  logic [IDX_W-1:0] iEff, jEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlR    <= '0;
      sMaskR <= '0;
      dMaskR <= '0;
      sBaseR <= '0;
      dBaseR <= '0;
      sVecR  <= 1'b0;
      dVecR  <= 1'b0;
    end else if (strobe.load) begin
      vlR    <= vecLen;
      sMaskR <= srcMask;
      dMaskR <= dstMask;
      sBaseR <= srcBase;
      dBaseR <= dstBase;
      sVecR  <= srcVec;
      dVecR  <= dstVec;
    end
  end

  // Priority search per side, both in the same cycle
  pms_first_set #(.VLMAX(VLMAX)) u_srcSkip (
    .mask    (sMaskR),
    .fromPos (iCur),
    .hitPos  (iHit)
  );

  pms_first_set #(.VLMAX(VLMAX)) u_dstSkip (
    .mask    (dMaskR),
    .fromPos (jCur),
    .hitPos  (jHit)
  );

  // Scalar sides ignore their mask and stay on their position
  assign iEff = sVecR ? iHit : iCur;
  assign jEff = dVecR ? jHit : jCur;

  assign endHit = spent || (iEff >= vlR) || (jEff >= vlR);

  assign cpSrc = sBaseR + REG_W'(iEff);
  assign cpDst = dBaseR + REG_W'(jEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iCur  <= '0;
      jCur  <= '0;
      spent <= 1'b0;
    end else if (strobe.load) begin
      iCur  <= '0;
      jCur  <= '0;
      spent <= 1'b0;
    end else if (strobe.step) begin
      if (sVecR) iCur <= iEff + IDX_W'(1);
      if (dVecR) jCur <= jEff + IDX_W'(1);
      spent <= !sVecR && !dVecR;
    end
  end

  AST_SCALAR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !sVecR && !dVecR) |=> endHit);  // R6

  AST_POS_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ((iCur >= $past(iCur)) && (jCur >= $past(jCur))));  // R4

  AST_SCALAR_POS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !sVecR) |=> (iCur == $past(iCur)));  // R4

endmodule

// File: rtl/pms_control.sv
module pms_control
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cpReady,
  input  logic       endHit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       cpValid,
  output logic       done
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    cpValid  = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNxt    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (endHit) begin
          done     = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          cpValid     = 1'b1;
          strobe.step = cpReady;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_RUN);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cpValid && !done));  // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));  // R7

  AST_VALID_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(cpValid && done));  // R7

endmodule

// File: rtl/pred_move_seq.sv
module pred_move_seq
  import pms_pkg::*;
#(
  parameter int VLMAX = 8,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] vecLen,
  input  logic [VLMAX-1:0] srcMask,
  input  logic [VLMAX-1:0] dstMask,
  input  logic [REG_W-1:0] srcBase,
  input  logic [REG_W-1:0] dstBase,
  input  logic             srcVec,
  input  logic             dstVec,
  input  logic             cpReady,
  output logic             busy,
  output logic             cpValid,
  output logic [REG_W-1:0] cpSrc,
  output logic [REG_W-1:0] cpDst,
  output logic             done
);

  seqStrobe_t strobe;
  logic       endHit;

  pms_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cpReady (cpReady),
    .endHit  (endHit),
    .strobe  (strobe),
    .busy    (busy),
    .cpValid (cpValid),
    .done    (done)
  );

  pms_datapath #(.VLMAX(VLMAX), .REG_W(REG_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .vecLen  (vecLen),
    .srcMask (srcMask),
    .dstMask (dstMask),
    .srcBase (srcBase),
    .dstBase (dstBase),
    .srcVec  (srcVec),
    .dstVec  (dstVec),
    .endHit  (endHit),
    .cpSrc   (cpSrc),
    .cpDst   (cpDst)
  );

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (cpValid && !cpReady) |=> (cpValid && $stable(cpSrc) && $stable(cpDst)));  // R8

endmodule

// File: tb/pred_move_seq_tb.sv
module pred_move_seq_tb;

  localparam int VLMAX      = 8;
  localparam int REG_W      = 5;
  localparam int IDX_W      = $clog2(VLMAX + 1);
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] vl;
    logic [7:0] sm;
    logic [7:0] dm;
    logic       sv;
    logic       dv;
    logic [4:0] sb;
    logic [4:0] db;
    logic [4:0] cnt;   // expected number of requests
    logic [1:0] rdy;   // ready pattern
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{4'd4, 8'h00, 8'hFF, 1'b0, 1'b1, 5'd3,  5'd10, 5'd4, 2'd0},  // splat, src mask ignored (R9)
    '{4'd8, 8'h00, 8'hA4, 1'b0, 1'b1, 5'd7,  5'd0,  5'd3, 2'd1},  // sparse splat
    '{4'd8, 8'h10, 8'hFF, 1'b1, 1'b0, 5'd2,  5'd9,  5'd1, 2'd0},  // extract
    '{4'd5, 8'hFF, 8'hFF, 1'b1, 1'b1, 5'd0,  5'd16, 5'd5, 2'd1},  // copy
    '{4'd8, 8'hC3, 8'hFF, 1'b1, 1'b1, 5'd1,  5'd20, 5'd4, 2'd0},  // gather
    '{4'd6, 8'hFF, 8'h2A, 1'b1, 1'b1, 5'd4,  5'd8,  5'd3, 2'd1},  // scatter
    '{4'd8, 8'h69, 8'h94, 1'b1, 1'b1, 5'd0,  5'd0,  5'd3, 2'd1},  // gather/scatter, skip to end
    '{4'd3, 8'h00, 8'h00, 1'b0, 1'b0, 5'd6,  5'd7,  5'd1, 2'd1},  // scalar-scalar (R6)
    '{4'd0, 8'hFF, 8'hFF, 1'b1, 1'b1, 5'd0,  5'd0,  5'd0, 2'd0},  // zero length
    '{4'd8, 8'h00, 8'hFF, 1'b1, 1'b1, 5'd0,  5'd0,  5'd0, 2'd0},  // empty source mask
    '{4'd4, 8'h06, 8'h00, 1'b1, 1'b0, 5'd5,  5'd1,  5'd2, 2'd1},  // dst mask ignored (R9)
    '{4'd4, 8'hFF, 8'hFF, 1'b1, 1'b1, 5'd30, 5'd28, 5'd4, 2'd1},  // index wrap (R3)
    '{4'd3, 8'hF8, 8'hFF, 1'b1, 1'b1, 5'd0,  5'd0,  5'd0, 2'd0},  // mask only above length
    '{4'd8, 8'hFF, 8'hFF, 1'b1, 1'b1, 5'd0,  5'd8,  5'd8, 2'd1}   // full length
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [IDX_W-1:0] vecLen = '0;
  logic [VLMAX-1:0] srcMask = '0, dstMask = '0;
  logic [REG_W-1:0] srcBase = '0, dstBase = '0;
  logic             srcVec = 1'b0, dstVec = 1'b0;
  logic             cpReady = 1'b0;
  logic             busy, cpValid, done;
  logic [REG_W-1:0] cpSrc, cpDst;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pred_move_seq #(.VLMAX(VLMAX), .REG_W(REG_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .srcMask(srcMask), .dstMask(dstMask), .srcBase(srcBase), .dstBase(dstBase),
    .srcVec(srcVec), .dstVec(dstVec), .cpReady(cpReady),
    .busy(busy), .cpValid(cpValid), .cpSrc(cpSrc), .cpDst(cpDst), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit readyAt(input int mode, input int n);
    case (mode)
      0: return 1'b1;
      1: return (n % 3) != 1;
      default: return n >= 3;
    endcase
  endfunction

  // Run one move; disturb = 1 pulses start with other operands while busy
  task automatic runMove(input int vl, input logic [7:0] sm, input logic [7:0] dm,
                         input bit sv, input bit dv, input int sb, input int db,
                         input int expCnt, input int mode, input bit disturb,
                         input int tIdx);
    int expS[16];
    int expD[16];
    int mc, i, j, k, lastAcc, holdS, holdD;
    bit holdV, sawDone;
    // Reference walk from the requirements
    mc = 0; i = 0; j = 0;
    for (int it = 0; it < 2 * VLMAX + 2; it++) begin
      if (sv) while (i < vl && !sm[i]) i++;
      if (dv) while (j < vl && !dm[j]) j++;
      if (i >= vl || j >= vl) break;
      expS[mc] = (sb + i) % (1 << REG_W);
      expD[mc] = (db + j) % (1 << REG_W);
      mc++;
      if (!sv && !dv) break;
      if (sv) i++;
      if (dv) j++;
    end

    @(negedge clk);
    vecLen = IDX_W'(vl); srcMask = sm; dstMask = dm;
    srcBase = REG_W'(sb); dstBase = REG_W'(db);
    srcVec = sv; dstVec = dv; start = 1'b1; cpReady = 1'b0;

    k = 0; lastAcc = -1; holdV = 1'b0; holdS = 0; holdD = 0; sawDone = 1'b0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (disturb && n == 1) begin
        start = 1'b1; vecLen = IDX_W'(VLMAX); srcBase = 5'd20;
        srcMask = '0; dstMask = '0;
      end
      cpReady = readyAt(mode, n);
      if (holdV) begin
        chk(cpValid && cpSrc == REG_W'(holdS) && cpDst == REG_W'(holdD),
            "R8", $sformatf("held request vec%0d", tIdx), int'(cpSrc), holdS);
      end
      holdV = cpValid && !cpReady;
      holdS = int'(cpSrc); holdD = int'(cpDst);
      if (cpValid && cpReady) begin
        if (k < mc) begin
          chk(cpSrc == REG_W'(expS[k]), "R3",
              $sformatf("src of copy %0d vec%0d", k, tIdx), int'(cpSrc), expS[k]);
          chk(cpDst == REG_W'(expD[k]), "R4",
              $sformatf("dst of copy %0d vec%0d", k, tIdx), int'(cpDst), expD[k]);
        end
        k++;
        lastAcc = n;
      end
      if (done) begin
        chk(n == ((k == 0) ? 0 : lastAcc + 1), "R7",
            $sformatf("done cycle vec%0d", tIdx), n, (k == 0) ? 0 : lastAcc + 1);
        sawDone = 1'b1;
        break;
      end
    end
    cpReady = 1'b0;
    chk(sawDone, "R7", $sformatf("done seen vec%0d", tIdx), int'(sawDone), 1);
    chk(k == expCnt, "R5", $sformatf("request count vec%0d", tIdx), k, expCnt);
    @(negedge clk);
    chk(!done && !busy, "R7", $sformatf("single done pulse vec%0d", tIdx),
        int'(done) + 2 * int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy, "R1", "busy after reset", int'(busy), 0);
    chk(!cpValid, "R1", "cpValid after reset", int'(cpValid), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);

    // Table walk: R3 R4 R5 R6 R7 R8 R9
    for (int t = 0; t < NVEC; t++) begin
      runMove(int'(VECS[t].vl), VECS[t].sm, VECS[t].dm, VECS[t].sv, VECS[t].dv,
              int'(VECS[t].sb), int'(VECS[t].db), int'(VECS[t].cnt),
              int'(VECS[t].rdy), 1'b0, t);
    end

    // R2: start and operand changes while busy are ignored
    runMove(3, 8'hFF, 8'hFF, 1'b1, 1'b1, 0, 8, 3, 2, 1'b1, 100);

    // R6: scalar-scalar under a long stall still gives one request
    runMove(1, 8'h00, 8'hFF, 1'b0, 1'b0, 31, 0, 1, 2, 1'b0, 101);

    // R1: idle with no start stays quiet
    repeat (3) @(negedge clk);
    chk(!busy && !cpValid && !done, "R1", "idle quiet",
        int'(busy) + int'(cpValid) + int'(done), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule